// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block merges a set of serial-interrupt lines and a handful of bus event inputs into a single interrupt level for a processor. The sources feed a first-level status register. The first level masks that status and gates it with a global enable. Its combined result becomes one bit of a second-level input vector. The second level latches the masked input into a sticky status register, and the processor interrupt is asserted while that latch holds any bit.

Software reaches both levels through one 32-bit register port. A bank select input picks the level, and a byte offset picks the register. Status registers at both levels can only be set by hardware and cleared by software, using write-one-to-clear. The second level keeps its latched bits after the first level has been cleared. Software therefore acknowledges in two steps: it clears the source status first, then the latch. A few storage-only registers (two routing words, a polarity word and a firmware read-size word) sit beside the functional ones and have no effect on the interrupt path.

Top module: `irq_aggregator`

## Requirements
- R1: A high level on serial line n (n = 0..16) during a clock edge sets first-level status bit 31−n. The bit stays set after the line returns low.
- R2: The event inputs set further first-level status bits:
  - the reset-seen event sets bit 10;
  - sync-error input k (k = 0..5) sets bit 2+k;
  - bus-master request j (j = 0..1) sets bit j.
  - No other status bit can ever become set.
- R3: Writing first-level status (bank 0, offset 0x38) clears every bit written as one and leaves bits written as zero. A source that sets a bit in the same cycle as a clear of that bit wins.
- R4: The first-level combined output is high exactly when control bit 31 (bank 0, offset 0x30) is set and status AND mask (bank 0, offset 0x34) is nonzero. It is readable as bit 11 of the read-only second-level input register (bank 1, offset 0x5C); all other bits of that register read zero.
- R5: Second-level status (bank 1, offset 0x50) ORs in input AND mask (bank 1, offset 0x54) on every cycle. Its bits stay set after the input falls. A write clears the bits written as one, but a clear has no lasting effect while the masked input is still high.
- R6: `cpu_irq` is high exactly when second-level status is nonzero. It changes at the same clock edge that captures the source event or register write causing the change.
- R7: The routing words (bank 1, 0x08 and 0x0C), the polarity word (bank 1, 0x58) and the read-size word (bank 0, 0x28) are plain read/write storage with no effect on `cpu_irq`. Reset values: read-size 0x02000000; every other register 0.
- R8: Reads of unimplemented offsets in either bank return 0xFFFFFFFF, and writes to them change nothing. The error-address register (bank 0, 0x40) reads 0 and ignores writes, as does the input register (bank 1, 0x5C).
- R9: `reg_bank` = 0 selects the first level and 1 the second level. `reg_rdata` is a combinational function of the current bank, offset and register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_bank | input | 1 | 0 = first level, 1 = second level |
| reg_addr | input | 8 | Byte offset within the selected bank |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| serial_irq | input | 17 | Serial-interrupt source lines, active high |
| lreset_evt | input | 1 | Bus reset-seen event |
| sync_err | input | 6 | Sync and turnaround error events |
| bm_req | input | 2 | Bus-master request events |
| cpu_irq | output | 1 | Level interrupt to the processor |

## Verification
The assertions assume that source inputs and register strobes are sampled only at rising edges and are stable around them. They also assume that reset is held for at least one edge, so that every `$past` value is a reset value or a captured one. The bench meets this by changing every input on the falling edge and holding each write strobe for exactly one rising edge. It never drives a write and a source onto the same bit except in the one deliberate collision case. Beyond that, the latch invariant takes for granted that the second-level mask bit 11 and the combined first-level output are both derived from registered state. No input feeds them combinationally, so the invariant holds in every cycle.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;
  localparam int REG_W      = 32;
  localparam int ADDR_W     = 8;
  localparam int MAX_SERIAL = 17;
  localparam int ERR_W      = 6;
  localparam int BM_W       = 2;

  // bit positions the decode logic depends on
  localparam int EN_BIT       = 31;
  localparam int LRST_BIT     = 10;
  localparam int ERR_LO_BIT   = 2;
  localparam int AGG_IN_BIT   = 11;

  // first level offsets (bank 0)
  localparam logic [ADDR_W-1:0] L1_RDSIZE = 8'h28;
  localparam logic [ADDR_W-1:0] L1_CTRL   = 8'h30;
  localparam logic [ADDR_W-1:0] L1_MASK   = 8'h34;
  localparam logic [ADDR_W-1:0] L1_STAT   = 8'h38;
  localparam logic [ADDR_W-1:0] L1_ERRADR = 8'h40;
  // second level offsets (bank 1)
  localparam logic [ADDR_W-1:0] L2_ROUTEA = 8'h08;
  localparam logic [ADDR_W-1:0] L2_ROUTEB = 8'h0C;
  localparam logic [ADDR_W-1:0] L2_STAT   = 8'h50;
  localparam logic [ADDR_W-1:0] L2_MASK   = 8'h54;
  localparam logic [ADDR_W-1:0] L2_POL    = 8'h58;
  localparam logic [ADDR_W-1:0] L2_INPUT  = 8'h5C;

  localparam logic [REG_W-1:0] RDSIZE_RST = 32'h0200_0000;
  localparam logic [REG_W-1:0] ALL_ONES   = '1;
  // every first-level status bit a source can reach
  localparam logic [REG_W-1:0] L1_DEFINED = 32'hFFFF_84FF;

  // serial line n lands on status bit REG_W-1-n
  function automatic logic [REG_W-1:0] serial_bits(input logic [MAX_SERIAL-1:0] lines);
    logic [REG_W-1:0] v;
    v = '0;
    for (int n = 0; n < MAX_SERIAL; n++) v[REG_W-1-n] = lines[n];
    return v;
  endfunction

  function automatic logic [REG_W-1:0] event_bits(input logic [MAX_SERIAL-1:0] lines,
                                                  input logic lrst,
                                                  input logic [ERR_W-1:0] err,
                                                  input logic [BM_W-1:0] bm);
    logic [REG_W-1:0] v;
    v = serial_bits(lines);
    v[LRST_BIT] = lrst;
    v[ERR_LO_BIT +: ERR_W] = err;
    v[BM_W-1:0] = bm;
    return v;
  endfunction

  // hardware set dominates a software clear
  function automatic logic [REG_W-1:0] w1c_merge(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] clr,
                                                 input logic [REG_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic level_active(input logic [REG_W-1:0] ctrl,
                                        input logic [REG_W-1:0] stat,
                                        input logic [REG_W-1:0] mask);
    return ctrl[EN_BIT] && ((stat & mask) != '0);
  endfunction

  function automatic logic [REG_W-1:0] agg_to_input(input logic agg);
    logic [REG_W-1:0] v;
    v = '0;
    v[AGG_IN_BIT] = agg;
    return v;
  endfunction
endpackage

// File: rtl/irqagg_src_stage.sv
`timescale 1ns/1ps
module irqagg_src_stage
  import irqagg_pkg::*;
#(
  parameter int NUM_SERIAL = MAX_SERIAL
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_ctrl,
  input  logic                  wr_mask,
  input  logic                  wr_stat,
  input  logic                  wr_rdsize,
  input  logic [REG_W-1:0]      wdata,
  input  logic [NUM_SERIAL-1:0] serial_in,
  input  logic                  lrst_evt,
  input  logic [ERR_W-1:0]      err_evt,
  input  logic [BM_W-1:0]       bm_evt,
  output logic [REG_W-1:0]      ctrl_q,
  output logic [REG_W-1:0]      mask_q,
  output logic [REG_W-1:0]      stat_q,
  output logic [REG_W-1:0]      rdsize_q,
  output logic                  agg_now,
  output logic                  agg_next
);
  logic [MAX_SERIAL-1:0] serial_pad;
  logic [REG_W-1:0]      set_vec;
  logic [REG_W-1:0]      clr_vec;
  logic [REG_W-1:0]      ctrl_d, mask_d, stat_d;

  generate
    if (NUM_SERIAL < MAX_SERIAL) begin : g_pad
      assign serial_pad = {{(MAX_SERIAL-NUM_SERIAL){1'b0}}, serial_in};
    end else begin : g_full
      assign serial_pad = serial_in[MAX_SERIAL-1:0];
    end
  endgenerate

  assign set_vec = event_bits(serial_pad, lrst_evt, err_evt, bm_evt);
  assign clr_vec = wr_stat ? wdata : '0;

  always_comb begin
    ctrl_d = wr_ctrl ? wdata : ctrl_q;
    mask_d = wr_mask ? wdata : mask_q;
    stat_d = w1c_merge(stat_q, clr_vec, set_vec);
  end

  // combined output from current state and from the state after this edge
  assign agg_now  = level_active(ctrl_q, stat_q, mask_q);
  assign agg_next = level_active(ctrl_d, stat_d, mask_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      mask_q   <= '0;
      stat_q   <= '0;
      rdsize_q <= RDSIZE_RST;
    end else begin
      ctrl_q <= ctrl_d;
      mask_q <= mask_d;
      stat_q <= stat_d;
      if (wr_rdsize) rdsize_q <= wdata;
    end
  end

  // R1 / R3: a source event is always present in status after the edge
  a_r1_source_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R1: without a status write no bit ever drops
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R2: only defined bits can be set
  a_r2_defined_only: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~L1_DEFINED) == '0);
endmodule

// File: rtl/irqagg_latch_stage.sv
`timescale 1ns/1ps
module irqagg_latch_stage
  import irqagg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_route_a,
  input  logic             wr_route_b,
  input  logic             wr_stat,
  input  logic             wr_mask,
  input  logic             wr_pol,
  input  logic [REG_W-1:0] wdata,
  input  logic             agg_now,
  input  logic             agg_next,
  output logic [REG_W-1:0] route_a_q,
  output logic [REG_W-1:0] route_b_q,
  output logic [REG_W-1:0] stat_q,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] pol_q,
  output logic [REG_W-1:0] input_vec,
  output logic             irq_q
);
  logic [REG_W-1:0] mask_d, stat_d, in_next, clr_vec;

  assign input_vec = agg_to_input(agg_now);
  assign in_next   = agg_to_input(agg_next);
  assign clr_vec   = wr_stat ? wdata : '0;

  always_comb begin
    mask_d = wr_mask ? wdata : mask_q;
    stat_d = w1c_merge(stat_q, clr_vec, in_next & mask_d);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_a_q <= '0;
      route_b_q <= '0;
      stat_q    <= '0;
      mask_q    <= '0;
      pol_q     <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_route_a) route_a_q <= wdata;
      if (wr_route_b) route_b_q <= wdata;
      if (wr_pol)     pol_q     <= wdata;
      mask_q <= mask_d;
      stat_q <= stat_d;
      irq_q  <= (stat_d != '0);
    end
  end

  // R5: a masked, high input is always reflected in the latch
  a_r5_latch_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (agg_now && mask_q[AGG_IN_BIT]) |-> stat_q[AGG_IN_BIT]);

  // R5: latch bits only drop after a status write
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R6: output level agrees with latched status
  a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (stat_q != '0));

  // R4: only the aggregation bit of the input vector is ever driven
  a_r4_input_shape: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(input_vec) <= 1 && (input_vec[AGG_IN_BIT] == agg_now));
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int NUM_SERIAL = MAX_SERIAL
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_bank,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic [NUM_SERIAL-1:0] serial_irq,
  input  logic                  lreset_evt,
  input  logic [ERR_W-1:0]      sync_err,
  input  logic [BM_W-1:0]       bm_req,
  output logic                  cpu_irq
);
  logic wr_l1, wr_l2;
  logic [REG_W-1:0] l1_ctrl, l1_mask, l1_stat, l1_rdsize;
  logic [REG_W-1:0] l2_route_a, l2_route_b, l2_stat, l2_mask, l2_pol, l2_input;
  logic agg_now, agg_next;

  assign wr_l1 = reg_wr && !reg_bank;
  assign wr_l2 = reg_wr &&  reg_bank;

  irqagg_src_stage #(.NUM_SERIAL(NUM_SERIAL)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_l1 && reg_addr == L1_CTRL),
    .wr_mask  (wr_l1 && reg_addr == L1_MASK),
    .wr_stat  (wr_l1 && reg_addr == L1_STAT),
    .wr_rdsize(wr_l1 && reg_addr == L1_RDSIZE),
    .wdata    (reg_wdata),
    .serial_in(serial_irq),
    .lrst_evt (lreset_evt),
    .err_evt  (sync_err),
    .bm_evt   (bm_req),
    .ctrl_q   (l1_ctrl),
    .mask_q   (l1_mask),
    .stat_q   (l1_stat),
    .rdsize_q (l1_rdsize),
    .agg_now  (agg_now),
    .agg_next (agg_next)
  );

  irqagg_latch_stage u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_route_a(wr_l2 && reg_addr == L2_ROUTEA),
    .wr_route_b(wr_l2 && reg_addr == L2_ROUTEB),
    .wr_stat   (wr_l2 && reg_addr == L2_STAT),
    .wr_mask   (wr_l2 && reg_addr == L2_MASK),
    .wr_pol    (wr_l2 && reg_addr == L2_POL),
    .wdata     (reg_wdata),
    .agg_now   (agg_now),
    .agg_next  (agg_next),
    .route_a_q (l2_route_a),
    .route_b_q (l2_route_b),
    .stat_q    (l2_stat),
    .mask_q    (l2_mask),
    .pol_q     (l2_pol),
    .input_vec (l2_input),
    .irq_q     (cpu_irq)
  );

  always_comb begin
    reg_rdata = ALL_ONES;
    if (!reg_bank) begin
      case (reg_addr)
        L1_RDSIZE: reg_rdata = l1_rdsize;
        L1_CTRL:   reg_rdata = l1_ctrl;
        L1_MASK:   reg_rdata = l1_mask;
        L1_STAT:   reg_rdata = l1_stat;
        L1_ERRADR: reg_rdata = '0;
        default:   reg_rdata = ALL_ONES;
      endcase
    end else begin
      case (reg_addr)
        L2_ROUTEA: reg_rdata = l2_route_a;
        L2_ROUTEB: reg_rdata = l2_route_b;
        L2_STAT:   reg_rdata = l2_stat;
        L2_MASK:   reg_rdata = l2_mask;
        L2_POL:    reg_rdata = l2_pol;
        L2_INPUT:  reg_rdata = l2_input;
        default:   reg_rdata = ALL_ONES;
      endcase
    end
  end

  // R4: when disabled, the first level can never raise the latch
  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !l1_ctrl[EN_BIT] |-> !l2_input[AGG_IN_BIT]);
endmodule

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_bank = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [16:0] serial_irq = '0;
  logic        lreset_evt = 1'b0;
  logic [5:0]  sync_err = '0;
  logic [1:0]  bm_req = '0;
  logic        cpu_irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_bank(reg_bank),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .serial_irq(serial_irq), .lreset_evt(lreset_evt), .sync_err(sync_err),
    .bm_req(bm_req), .cpu_irq(cpu_irq)
  );

  // vector: serial[58:42] lrst[41] err[40:35] bm[34:33] mask[32:1] en[0]
  localparam int NV = 6;
  localparam logic [58:0] VEC [NV] = '{
    {17'h00001, 1'b0, 6'b000000, 2'b00, 32'h8000_0000, 1'b1},
    {17'h10000, 1'b0, 6'b000000, 2'b00, 32'h0000_8000, 1'b0},
    {17'h00000, 1'b0, 6'b100001, 2'b00, 32'h0000_0004, 1'b1},
    {17'h00000, 1'b1, 6'b000000, 2'b10, 32'h0000_0001, 1'b1},
    {17'h1FFFF, 1'b0, 6'b000000, 2'b00, 32'h0000_0000, 1'b1},
    {17'h00100, 1'b0, 6'b000000, 2'b00, 32'hFFFF_FFFF, 1'b1}
  };

  function automatic logic [31:0] expect_l1(input logic [16:0] s, input logic l,
                                            input logic [5:0] e, input logic [1:0] b);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 17; i++) if (s[i]) r = r | (32'h8000_0000 >> i);
    if (l) r = r | 32'h0000_0400;
    r = r | ({26'd0, e} << 2) | {30'd0, b};
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic bank, input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_bank = bank; reg_addr = addr; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic bank, input logic [7:0] addr, output logic [31:0] data);
    reg_bank = bank; reg_addr = addr;
    #1 data = reg_rdata;
  endtask

  task automatic pulse(input logic [16:0] s, input logic l, input logic [5:0] e,
                       input logic [1:0] b);
    @(negedge clk);
    serial_irq = s; lreset_evt = l; sync_err = e; bm_req = b;
    @(negedge clk);
    serial_irq = '0; lreset_evt = 1'b0; sync_err = '0; bm_req = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] e1;
    logic        agg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R7, R8, R6)
    check("R6 cpu_irq after reset", {31'd0, cpu_irq}, 32'd0);
    rd(0, 8'h28, d); check("R7 read-size reset", d, 32'h0200_0000);
    rd(0, 8'h30, d); check("R7 control reset", d, 32'h0);
    rd(1, 8'h50, d); check("R7 latch reset", d, 32'h0);
    rd(0, 8'h40, d); check("R8 error address reset", d, 32'h0);
    rd(0, 8'h00, d); check("R8 unimplemented bank0", d, 32'hFFFF_FFFF);
    rd(1, 8'h60, d); check("R9 unimplemented bank1", d, 32'hFFFF_FFFF);

    // vector table walk (R1, R2, R4, R5, R6)
    wr(1, 8'h54, 32'h0000_0800);
    for (int v = 0; v < NV; v++) begin
      wr(0, 8'h30, 32'h0);
      wr(0, 8'h38, 32'hFFFF_FFFF);
      wr(1, 8'h50, 32'hFFFF_FFFF);
      check("R6 idle before vector", {31'd0, cpu_irq}, 32'd0);
      wr(0, 8'h34, VEC[v][32:1]);
      wr(0, 8'h30, {VEC[v][0], 31'd0});
      pulse(VEC[v][58:42], VEC[v][41], VEC[v][40:35], VEC[v][34:33]);
      e1  = expect_l1(VEC[v][58:42], VEC[v][41], VEC[v][40:35], VEC[v][34:33]);
      agg = VEC[v][0] && ((e1 & VEC[v][32:1]) != 0);
      rd(0, 8'h38, d); check("R1 R2 first-level status", d, e1);
      rd(1, 8'h5C, d); check("R4 input register", d, {20'd0, agg, 11'd0});
      check("R6 cpu_irq follows", {31'd0, cpu_irq}, {31'd0, agg});
      rd(1, 8'h50, d); check("R5 latch status", d, {20'd0, agg, 11'd0});
    end

    // R3: clear and set in the same cycle, set wins
    wr(0, 8'h30, 32'h8000_0000);
    wr(0, 8'h34, 32'hFFFF_FFFF);
    wr(0, 8'h38, 32'hFFFF_FFFF);
    wr(1, 8'h50, 32'hFFFF_FFFF);
    @(negedge clk);
    reg_wr = 1'b1; reg_bank = 1'b0; reg_addr = 8'h38; reg_wdata = 32'h8000_0000;
    serial_irq = 17'h00001;
    @(negedge clk);
    reg_wr = 1'b0; serial_irq = '0;
    rd(0, 8'h38, d); check("R3 set beats clear", d, 32'h8000_0000);
    wr(0, 8'h38, 32'h4000_0000);
    rd(0, 8'h38, d); check("R3 zero bits untouched", d, 32'h8000_0000);
    wr(0, 8'h38, 32'h8000_0000);
    rd(0, 8'h38, d); check("R3 one bit clears", d, 32'h0);

    // R5: sticky latch and two-step acknowledge
    wr(1, 8'h50, 32'hFFFF_FFFF);
    pulse(17'h00008, 1'b0, 6'd0, 2'd0);
    check("R6 raised by source", {31'd0, cpu_irq}, 32'd1);
    wr(1, 8'h50, 32'h0000_0800);
    rd(1, 8'h50, d); check("R5 clear while input high", d, 32'h0000_0800);
    wr(0, 8'h38, 32'hFFFF_FFFF);
    rd(1, 8'h5C, d); check("R4 input dropped", d, 32'h0);
    rd(1, 8'h50, d); check("R5 latch holds after drop", d, 32'h0000_0800);
    check("R5 cpu_irq holds", {31'd0, cpu_irq}, 32'd1);
    wr(1, 8'h50, 32'h0000_0800);
    check("R6 cleared with latch", {31'd0, cpu_irq}, 32'd0);

    // R6: latency of a mask write with input already high
    wr(1, 8'h54, 32'h0);
    pulse(17'h00002, 1'b0, 6'd0, 2'd0);
    check("R6 masked second level stays low", {31'd0, cpu_irq}, 32'd0);
    wr(1, 8'h54, 32'h0000_0800);
    check("R6 one edge after mask write", {31'd0, cpu_irq}, 32'd1);

    // R4: disable removes combined output but latch stays
    wr(0, 8'h30, 32'h0);
    rd(1, 8'h5C, d); check("R4 disable gates output", d, 32'h0);

    // R7: storage-only registers
    wr(1, 8'h08, 32'h1234_5678);
    rd(1, 8'h08, d); check("R7 route A storage", d, 32'h1234_5678);
    wr(1, 8'h0C, 32'hCAFE_F00D);
    rd(1, 8'h0C, d); check("R7 route B storage", d, 32'hCAFE_F00D);
    wr(1, 8'h58, 32'hFFFF_FFFF);
    rd(1, 8'h58, d); check("R7 polarity storage", d, 32'hFFFF_FFFF);
    check("R7 polarity no effect", {31'd0, cpu_irq}, 32'd1);
    wr(0, 8'h28, 32'h0700_0000);
    rd(0, 8'h28, d); check("R7 read-size storage", d, 32'h0700_0000);

    // R8: ignored writes
    wr(0, 8'h44, 32'h0);
    rd(0, 8'h44, d); check("R8 unimplemented write ignored", d, 32'hFFFF_FFFF);
    wr(0, 8'h40, 32'h0000_ABCD);
    rd(0, 8'h40, d); check("R8 error address ignores write", d, 32'h0);
    wr(1, 8'h5C, 32'hFFFF_FFFF);
    rd(1, 8'h5C, d); check("R8 input register read-only", d, 32'h0);
    rd(1, 8'h50, d); check("R9 bank select latch", d, 32'h0000_0800);
    rd(0, 8'h34, d); check("R9 bank select first mask", d, 32'hFFFF_FFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule